// File: doc/BRIEF.md
# Packet-Filter VM Integer ALU

This block is the integer execution unit of a packet-filter virtual machine. The destination register value works as an accumulator. Each request carries an operation code, a mode bit that selects 64-bit or 32-bit arithmetic, the current destination value, a source register value and a 32-bit immediate. An operand-select bit chooses the second operand. The unit returns the new destination value one clock later, together with a valid strobe and an error flag.

The operation set covers add, subtract, multiply, unsigned divide and remainder, the three bitwise operations, three shifts, negate, move, sign-extending move and byte-order conversion. Byte-order conversion takes a width of 16, 32 or 64 bits. A parameter fixes the machine's native byte order, and the conversion swaps bytes only when the requested order differs from the native one. A request that cannot be encoded legally raises the error flag and returns the destination value unchanged. Register file, decode, memory access and branches belong to neighbouring blocks.

Top module: `vm_alu`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `out_val` and `out_err` are loaded only in cycles where `in_valid` is 1 and otherwise hold their values. Reset drives all three outputs to 0.
- R2: With `use_reg`=1 the second operand is `src_val`. With `use_reg`=0 it is `imm` sign-extended to 64 bits.
- R3: In 64-bit mode (`wide`=1) the following opcodes give the listed results: 0 add, 1 subtract, 2 low 64 bits of the product, 5 and, 6 or, 7 xor, 12 move (operand copied). Results wrap modulo 2^64.
- R4: In 32-bit mode (`wide`=0), opcodes 0 to 12 use only the low 32 bits of both values. The 32-bit result is zero-extended into bits 63:32.
- R5: Opcode 3 is an unsigned divide. A divisor of zero (checked at the active width) gives a result of 0.
- R6: Opcode 4 is an unsigned remainder. A divisor of zero returns the destination: the full value in 64-bit mode, and its low 32 bits zero-extended in 32-bit mode.
- R7: Opcode 8 is a left shift, 9 a logical right shift and 10 an arithmetic right shift, all of the destination. The count is the operand masked to 6 bits in 64-bit mode and to 5 bits in 32-bit mode. The arithmetic shift fills with the sign bit of the active width.
- R8: Opcode 11 negates the destination (0 minus destination) and ignores the operand. The request is legal only with `use_reg`=0. With `use_reg`=1 it is illegal.
- R9: Opcode 13 is a sign-extending move. It copies the low 8, 16 or 32 bits of the operand (`ext_sel` = 0, 1, 2) and sign-extends them to 64 bits. In 32-bit mode the low 32 bits of that value are then zero-extended. `ext_sel`=3 is illegal.
- R10: Opcode 14 converts the destination to little-endian and opcode 15 to big-endian, at a width given by `ext_sel` (0=16, 1=32, 2=64 bits); `ext_sel`=3 is illegal. When the target order differs from the native order (parameter `NATIVE_BIG`: 1 means big-endian), the bytes in the low width are reversed. When it matches, the low width is kept unchanged. Either way the bits above the width are zero. `wide` and the operand have no effect.
- R11: An illegal request (see R8, R9, R10) sets `out_err` to 1 and returns `dst_val` unchanged. Every legal request sets `out_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| use_reg | input | 1 | 1 = register operand, 0 = immediate |
| ext_sel | input | 2 | Width select for sign-extending move and byte-order conversion |
| dst_val | input | 64 | Current destination value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Signed immediate |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_val | output | 64 | New destination value |
| out_err | output | 1 | Illegal request flag |

## Verification
The sweep drives every opcode in both modes, with both operand-select settings and all four width codes, over operands picked for their edge behaviour. These include a divisor that is zero in both modes, a divisor that is zero only in its low half, shift counts above the mask, and sign bits set at bit 7, 15, 31 and 63. A design that tested the full 64-bit divisor in 32-bit mode would divide by zero. One that left the shift count unmasked would shift everything out. One that sign-extended 32-bit results would leave ones in the upper half.

Negate with the register setting and the width code 3 are checked for the error flag and an unchanged destination. A wrong design would return an arithmetic result with no error flagged. Two instances with opposite native byte order catch a swap that is inverted or applied at the wrong width.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;

    localparam int unsigned XLEN  = 64;
    localparam int unsigned HALF  = XLEN / 2;
    localparam int unsigned IMMW  = 32;
    localparam int unsigned BYTEW = 8;
    localparam int unsigned NBYTE = XLEN / BYTEW;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_DIV  = 4'd3,
        OP_MOD  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_SAR  = 4'd10,
        OP_NEG  = 4'd11,
        OP_MOV  = 4'd12,
        OP_MOVS = 4'd13,
        OP_TOLE = 4'd14,
        OP_TOBE = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic            err;
        logic [XLEN-1:0] val;
    } alu_res_t;

    // Sign-extend the low 8/16/32 bits of x; code 3 passes x through.
    function automatic logic [XLEN-1:0] sext_sel(logic [XLEN-1:0] x, logic [1:0] es);
        logic [XLEN-1:0] r;
        case (es)
            2'd0:    r = {{(XLEN-8){x[7]}}, x[7:0]};
            2'd1:    r = {{(XLEN-16){x[15]}}, x[15:0]};
            2'd2:    r = {{(XLEN-32){x[31]}}, x[31:0]};
            default: r = x;
        endcase
        return r;
    endfunction

    function automatic logic [XLEN-1:0] zext_half(logic [XLEN-1:0] x);
        return {{(XLEN-HALF){1'b0}}, x[HALF-1:0]};
    endfunction

    // Keep the low 2/4/8 bytes, optionally reversed; zero above.
    function automatic logic [XLEN-1:0] byte_order(logic [XLEN-1:0] x, logic [1:0] es, logic swap);
        logic [XLEN-1:0] r;
        int nb;
        int idx;
        r  = '0;
        nb = 2 << es;
        for (int i = 0; i < int'(NBYTE); i++) begin
            if (i < nb) begin
                idx = swap ? (nb - 1 - i) : i;
                r[BYTEW*i +: BYTEW] = x[BYTEW*idx +: BYTEW];
            end
        end
        return r;
    endfunction

    function automatic logic is_illegal(alu_op_e op, logic use_reg, logic [1:0] es);
        logic bad;
        bad = 1'b0;
        if (op == OP_NEG && use_reg)
            bad = 1'b1;
        if ((op == OP_MOVS || op == OP_TOLE || op == OP_TOBE) && es == 2'd3)
            bad = 1'b1;
        return bad;
    endfunction

endpackage

// File: rtl/vm_alu_operand.sv
module vm_alu_operand #(
    parameter int unsigned DW = 64,
    parameter int unsigned IW = 32
) (
    input  logic          use_reg,
    input  logic [DW-1:0] src_val,
    input  logic [IW-1:0] imm,
    output logic [DW-1:0] opnd
);
    localparam int unsigned PADW = DW - IW;

    always_comb begin
        if (use_reg)
            opnd = src_val;
        else
            opnd = {{PADW{imm[IW-1]}}, imm};
    end
endmodule

// File: rtl/vm_alu_arith.sv
module vm_alu_arith
    import vm_alu_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  res
);
    localparam int unsigned SHW = $clog2(W);

    logic [SHW-1:0] sh;
    logic           b_zero;
    logic [W-1:0]   prod;
    logic [W-1:0]   quot;
    logic [W-1:0]   rem;

    assign sh     = b[SHW-1:0];
    assign b_zero = (b == '0);
    assign prod   = a * b;
    assign quot   = b_zero ? '0 : (a / b);
    assign rem    = b_zero ? a : (a % b);

    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_MUL:  res = prod;
            OP_DIV:  res = quot;
            OP_MOD:  res = rem;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SHL:  res = a << sh;
            OP_SHR:  res = a >> sh;
            OP_SAR:  res = $unsigned($signed(a) >>> sh);
            OP_NEG:  res = '0 - a;
            OP_MOV:  res = b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/vm_alu_xform.sv
module vm_alu_xform
    import vm_alu_pkg::*;
#(
    parameter bit NATIVE_BIG = 1'b0
) (
    input  alu_op_e          op,
    input  logic             wide,
    input  logic [1:0]       ext_sel,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  res
);
    logic [XLEN-1:0] sx;
    logic            want_big;

    assign sx       = sext_sel(b, ext_sel);
    assign want_big = (op == OP_TOBE);

    always_comb begin
        case (op)
            OP_MOVS:         res = wide ? sx : zext_half(sx);
            OP_TOLE, OP_TOBE: res = byte_order(a, ext_sel, want_big != NATIVE_BIG);
            default:         res = '0;
        endcase
    end
endmodule

// File: rtl/vm_alu.sv
module vm_alu
    import vm_alu_pkg::*;
#(
    parameter bit NATIVE_BIG = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic             wide,
    input  logic             use_reg,
    input  logic [1:0]       ext_sel,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMMW-1:0]  imm,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_val,
    output logic             out_err
);
    alu_op_e         op_e;
    logic [XLEN-1:0] opnd;
    logic [XLEN-1:0] r_full;
    logic [HALF-1:0] r_half;
    logic [XLEN-1:0] r_xf;
    logic            is_xf;
    alu_res_t        nxt;

    assign op_e  = alu_op_e'(op);
    assign is_xf = (op_e == OP_MOVS) || (op_e == OP_TOLE) || (op_e == OP_TOBE);

    vm_alu_operand #(.DW(XLEN), .IW(IMMW)) u_opnd (
        .use_reg (use_reg),
        .src_val (src_val),
        .imm     (imm),
        .opnd    (opnd)
    );

    vm_alu_arith #(.W(XLEN)) u_full (
        .op  (op_e),
        .a   (dst_val),
        .b   (opnd),
        .res (r_full)
    );

    vm_alu_arith #(.W(HALF)) u_half (
        .op  (op_e),
        .a   (dst_val[HALF-1:0]),
        .b   (opnd[HALF-1:0]),
        .res (r_half)
    );

    vm_alu_xform #(.NATIVE_BIG(NATIVE_BIG)) u_xf (
        .op      (op_e),
        .wide    (wide),
        .ext_sel (ext_sel),
        .a       (dst_val),
        .b       (opnd),
        .res     (r_xf)
    );

    always_comb begin
        nxt.err = is_illegal(op_e, use_reg, ext_sel);
        if (nxt.err)
            nxt.val = dst_val;
        else if (is_xf)
            nxt.val = r_xf;
        else if (wide)
            nxt.val = r_full;
        else
            nxt.val = {{(XLEN-HALF){1'b0}}, r_half};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_val   <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_val <= nxt.val;
                out_err <= nxt.err;
            end
        end
    end
endmodule

// File: rtl/vm_alu_chk.sv
module vm_alu_chk
    import vm_alu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [3:0]       op,
    input logic             wide,
    input logic             use_reg,
    input logic [1:0]       ext_sel,
    input logic [XLEN-1:0]  dst_val,
    input logic [XLEN-1:0]  src_val,
    input logic             out_valid,
    input logic [XLEN-1:0]  out_val,
    input logic             out_err
);
    assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_val) && $stable(out_err)));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide && op <= 4'(OP_MOV)) |=> (out_err || out_val[XLEN-1:HALF] == '0));

    assert_div_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'(OP_DIV) && use_reg && src_val == '0) |=> (out_val == '0 && !out_err));

    assert_mod_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'(OP_MOD) && wide && use_reg && src_val == '0) |=> (out_val == $past(dst_val)));

    assert_neg_reg_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'(OP_NEG) && use_reg) |=> (out_err && out_val == $past(dst_val)));

    assert_endian16_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 4'(OP_TOLE) && ext_sel == 2'd0) |=> (out_val[XLEN-1:16] == '0));

    assert_bad_width_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 4'(OP_MOVS) && ext_sel == 2'd3) |=> (out_err && out_val == $past(dst_val)));
endmodule

bind vm_alu vm_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .wide      (wide),
    .use_reg   (use_reg),
    .ext_sel   (ext_sel),
    .dst_val   (dst_val),
    .src_val   (src_val),
    .out_valid (out_valid),
    .out_val   (out_val),
    .out_err   (out_err)
);

// File: tb/tb_vm_alu.sv
module tb_vm_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op;
    logic        wide;
    logic        use_reg;
    logic [1:0]  ext_sel;
    logic [63:0] dst_val;
    logic [63:0] src_val;
    logic [31:0] imm;
    logic        le_valid, be_valid, le_err, be_err;
    logic [63:0] le_val, be_val;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vm_alu #(.NATIVE_BIG(1'b0)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide),
        .use_reg(use_reg), .ext_sel(ext_sel), .dst_val(dst_val),
        .src_val(src_val), .imm(imm),
        .out_valid(le_valid), .out_val(le_val), .out_err(le_err)
    );

    vm_alu #(.NATIVE_BIG(1'b1)) dut_be (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide),
        .use_reg(use_reg), .ext_sel(ext_sel), .dst_val(dst_val),
        .src_val(src_val), .imm(imm),
        .out_valid(be_valid), .out_val(be_val), .out_err(be_err)
    );

    // Independent arithmetic model: returns {err, value}.
    function automatic logic [64:0] model(int o, bit w, bit ur, int es,
                                          logic [63:0] d, logic [63:0] s,
                                          logic [31:0] im, bit nbig);
        logic [63:0] b;
        longint unsigned x, y, r;
        int unsigned x32, y32, r32;
        int nbytes, srcb;
        bit swap;
        b = ur ? s : {{32{im[31]}}, im};
        if (o == 11 && ur) return {1'b1, d};
        if (o >= 13 && es == 3) return {1'b1, d};
        if (o >= 14) begin
            nbytes = 2 << es;
            swap = ((o == 15) != nbig);
            r = 0;
            for (int k = 0; k < nbytes; k++) begin
                srcb = swap ? (nbytes - 1 - k) : k;
                r = r | (((d >> (8*srcb)) & 64'hFF) << (8*k));
            end
            return {1'b0, r};
        end
        if (o == 13) begin
            case (es)
                0:       r = {{56{b[7]}}, b[7:0]};
                1:       r = {{48{b[15]}}, b[15:0]};
                default: r = {{32{b[31]}}, b[31:0]};
            endcase
            if (!w) r = r & 64'h0000_0000_FFFF_FFFF;
            return {1'b0, r};
        end
        if (w) begin
            x = d; y = b;
            case (o)
                0:  r = x + y;
                1:  r = x - y;
                2:  r = x * y;
                3:  r = (y == 0) ? 0 : x / y;
                4:  r = (y == 0) ? x : x % y;
                5:  r = x & y;
                6:  r = x | y;
                7:  r = x ^ y;
                8:  r = x << (y & 63);
                9:  r = x >> (y & 63);
                10: r = longint'($signed(x) >>> (y & 63));
                11: r = 0 - x;
                default: r = y;
            endcase
            return {1'b0, r};
        end
        x32 = d[31:0]; y32 = b[31:0];
        case (o)
            0:  r32 = x32 + y32;
            1:  r32 = x32 - y32;
            2:  r32 = x32 * y32;
            3:  r32 = (y32 == 0) ? 0 : x32 / y32;
            4:  r32 = (y32 == 0) ? x32 : x32 % y32;
            5:  r32 = x32 & y32;
            6:  r32 = x32 | y32;
            7:  r32 = x32 ^ y32;
            8:  r32 = x32 << (y32 & 31);
            9:  r32 = x32 >> (y32 & 31);
            10: r32 = int'($signed(x32) >>> (y32 & 31));
            11: r32 = 0 - x32;
            default: r32 = y32;
        endcase
        return {1'b0, 32'h0, r32};
    endfunction

    function automatic string tag(int o, bit w, bit ur, int es);
        if (o == 11 && ur) return "R8";
        if (o >= 13 && es == 3) return "R11";
        if (o >= 14) return "R10";
        if (o == 13) return "R9";
        if (o == 11) return "R8";
        if (o == 3) return "R5";
        if (o == 4) return "R6";
        if (o >= 8 && o <= 10) return "R7";
        if (!w) return "R4";
        return "R3";
    endfunction

    task automatic chk(string t, logic [63:0] act, logic [63:0] exp,
                       logic act_e, logic exp_e, logic act_v, logic exp_v);
        checks++;
        if (act !== exp || act_e !== exp_e || act_v !== exp_v) begin
            failures++;
            $display("FAIL %s op=%0d wide=%0b reg=%0b es=%0d actual=%h/err%0b/v%0b expected=%h/err%0b/v%0b",
                     t, op, wide, use_reg, ext_sel, act, act_e, act_v, exp, exp_e, exp_v);
        end
    endtask

    logic [63:0] vd [8];
    logic [63:0] vs [8];
    logic [31:0] vi [8];

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [64:0] e_le, e_be;
        logic [63:0] held;
        vd[0] = 64'h0000_0000_0000_0064; vs[0] = 64'h7;                   vi[0] = 32'h3;
        vd[1] = 64'hFFFF_FFFF_FFFF_FF80; vs[1] = 64'h0;                   vi[1] = 32'h0;
        vd[2] = 64'h8000_0000_1234_5678; vs[2] = 64'h47;                  vi[2] = 32'hFFFF_FFC1;
        vd[3] = 64'h0123_4567_89AB_CDEF; vs[3] = 64'hFFFF_FFFF_8000_0081; vi[3] = 32'h8000_0000;
        vd[4] = 64'hDEAD_BEEF_CAFE_F00D; vs[4] = 64'h0000_0001_0000_0000; vi[4] = 32'h21;
        vd[5] = 64'h7FFF_FFFF_FFFF_FFFF; vs[5] = 64'hFFFF_FFFF_FFFF_FFFF; vi[5] = 32'hFFFF_FFFF;
        vd[6] = 64'h0000_0000_8000_0000; vs[6] = 64'h3F;                  vi[6] = 32'h1F;
        vd[7] = 64'h1122_3344_5566_7788; vs[7] = 64'hFF;                  vi[7] = 32'h7F80;

        rst = 1'b1; in_valid = 1'b1; op = 4'd0; wide = 1'b1; use_reg = 1'b1;
        ext_sel = 2'd0; dst_val = 64'h5; src_val = 64'h6; imm = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", le_val, 64'h0, le_err, 1'b0, le_valid, 1'b0);
        rst = 1'b0;

        // R2: immediate -1 sign-extended; 5 + (-1) = 4
        op = 4'd0; wide = 1'b1; use_reg = 1'b0; imm = 32'hFFFF_FFFF; dst_val = 64'h5;
        @(negedge clk);
        chk("R2", le_val, 64'h4, le_err, 1'b0, le_valid, 1'b1);
        // R2: register operand selected over immediate
        use_reg = 1'b1; src_val = 64'h1_0000_0000;
        @(negedge clk);
        chk("R2", le_val, 64'h1_0000_0005, le_err, 1'b0, le_valid, 1'b1);
        held = le_val;

        // R1: idle cycle holds the output and drops the strobe
        in_valid = 1'b0; op = 4'd1; dst_val = 64'hABCD;
        @(negedge clk);
        chk("R1", le_val, held, le_err, 1'b0, le_valid, 1'b0);
        in_valid = 1'b1;

        for (int o = 0; o < 16; o++)
            for (int w = 0; w < 2; w++)
                for (int ur = 0; ur < 2; ur++)
                    for (int es = 0; es < 4; es++)
                        for (int v = 0; v < 8; v++) begin
                            op = 4'(o); wide = w[0]; use_reg = ur[0]; ext_sel = 2'(es);
                            dst_val = vd[v]; src_val = vs[v]; imm = vi[v];
                            e_le = model(o, w[0], ur[0], es, vd[v], vs[v], vi[v], 1'b0);
                            e_be = model(o, w[0], ur[0], es, vd[v], vs[v], vi[v], 1'b1);
                            @(negedge clk);
                            chk(tag(o, w[0], ur[0], es), le_val, e_le[63:0], le_err, e_le[64], le_valid, 1'b1);
                            chk(tag(o, w[0], ur[0], es), be_val, e_be[63:0], be_err, e_be[64], be_valid, 1'b1);
                        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule